// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an 8-pin general-purpose I/O port on a simple memory-mapped register bus. Software can read or write any subset of the pins in one bus access, with no read-modify-write sequence. The subset is chosen by address bits [9:2] of the access, which act as a per-pin mask. A set mask bit n selects pin n. The port holds an output latch and a direction register. It drives a per-pin output value and output enable to the pads, and it samples the pad levels through a two-stage synchronizer.

The bus is a single-cycle request interface. A request is made by raising `bus_en` for one clock, with `bus_we` high for a write or low for a read. Writes take effect at the clock edge that accepts them. Read data is registered: it appears on `bus_rdata` after the accepting edge and stays there until the next read.

Top module: `gpio_masked_port`

## Requirements
- R1: While `rst_n` is low, the output latch and the direction register are cleared, so every pin is an input (`pad_oe` = 0, `pad_out` = 0), and `bus_rdata` is cleared to 0.
- R2: A write to the data window (address bits [11:10] = 0) updates only the output bits n whose mask bit (address bit n+2) is 1. The other output bits keep their value. The result shows on `pad_out` one clock after the write. A mask of zero changes nothing.
- R3: A data write uses only `bus_wdata[7:0]`, where bit n belongs to pin n. Bits 31:8 of the write data have no effect.
- R4: A read of the data window returns, in bit n, the level of pin n when mask bit n is 1, and 0 otherwise. Bits 31:8 are always 0. The value appears on `bus_rdata` one clock after the read request.
- R5: The level of a pin whose direction bit is 1 is its driven output value. The level of a pin whose direction bit is 0 is its synchronized pad input.
- R6: A pad input change first reaches a read after two clock edges. A read accepted at the first or second edge after the change returns the old level. A read accepted at the third edge returns the new level.
- R7: The direction register sits at byte offset 0x400. A write there loads `bus_wdata[7:0]` in full, and a read returns it zero-extended. `pad_oe` equals the direction register, where 1 means output.
- R8: Address 0x3FC, the all-ones mask, writes all 8 output bits at once and reads all 8 pin levels at once.
- R9: A write to any address outside the data window and the direction register changes neither `pad_out` nor `pad_oe`. A read of such an address returns 0.
- R10: `bus_rdata` keeps its value on every cycle that carries no read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits [9:2] form the pin mask in the data window |
| bus_wdata | input | 32 | Write data; bits [7:0] are used |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Output value to the pads |
| pad_oe | output | 8 | Output enable to the pads (1 = drive) |

## Verification
Writes are due at the accepting edge, so `pad_out` and `pad_oe` are sampled at the falling edge that follows it. Read data is also due one edge after the request, and it is sampled at the next falling edge after the request has been dropped. A pad input change is due at reads two edges later. The random sequence therefore holds the bus idle for three cycles after each pad change before it reads. A directed sequence issues reads back to back straight after a change to show the old, old, new pattern of the synchronizer latency.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_DIR  = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n) chain_q[i] <= '0;
            else        chain_q[i] <= chain_d[i];
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int             AW         = 12,
    parameter int             NPINS      = 8,
    parameter logic [AW-1:0]  DIR_OFFSET = 'h400
) (
    input  logic [AW-1:0]    addr,
    output acc_kind_e        kind,
    output logic [NPINS-1:0] pin_mask
);
    localparam int MASK_LO = 2;
    localparam int MASK_HI = NPINS + 1;

    logic data_hit;
    logic dir_hit;
    logic unused_byte_lane;

    assign unused_byte_lane = ^addr[1:0];
    assign data_hit = (addr[AW-1:MASK_HI+1] == '0);
    assign dir_hit  = (addr[AW-1:2] == DIR_OFFSET[AW-1:2]);
    assign pin_mask = addr[MASK_HI:MASK_LO];

    always_comb begin
        if (data_hit)     kind = ACC_DATA;
        else if (dir_hit) kind = ACC_DIR;
        else              kind = ACC_NONE;
    end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int DW    = 32
) (
    input  acc_kind_e        kind,
    input  logic [NPINS-1:0] pin_mask,
    input  logic [NPINS-1:0] out_val,
    input  logic [NPINS-1:0] dir_val,
    input  logic [NPINS-1:0] pin_sync,
    output logic [DW-1:0]    word
);
    logic [NPINS-1:0] level;

    for (genvar n = 0; n < NPINS; n++) begin : g_level
        assign level[n] = dir_val[n] ? out_val[n] : pin_sync[n];
    end

    always_comb begin
        case (kind)
            ACC_DATA: word = DW'(level & pin_mask);
            ACC_DIR:  word = DW'(dir_val);
            default:  word = '0;
        endcase
    end
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
    import gpio_port_pkg::*;
#(
    parameter int             NPINS       = 8,
    parameter int             AW          = 12,
    parameter int             DW          = 32,
    parameter int             SYNC_STAGES = 2,
    parameter logic [AW-1:0]  DIR_OFFSET  = 'h400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    typedef struct packed {
        logic [NPINS-1:0] out;
        logic [NPINS-1:0] dir;
        logic [DW-1:0]    rdata;
    } port_state_t;

    port_state_t      state_d, state_q;
    acc_kind_e        acc_kind;
    logic [NPINS-1:0] acc_mask;
    logic [NPINS-1:0] pin_sync;
    logic [DW-1:0]    rd_word;
    logic [NPINS-1:0] wr_byte;
    logic             unused_wdata_hi;

    assign wr_byte         = bus_wdata[NPINS-1:0];
    assign unused_wdata_hi = ^bus_wdata[DW-1:NPINS];

    gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_addr_decode #(.AW(AW), .NPINS(NPINS), .DIR_OFFSET(DIR_OFFSET)) u_dec (
        .addr     (bus_addr),
        .kind     (acc_kind),
        .pin_mask (acc_mask)
    );

    gpio_read_mux #(.NPINS(NPINS), .DW(DW)) u_rmux (
        .kind     (acc_kind),
        .pin_mask (acc_mask),
        .out_val  (state_q.out),
        .dir_val  (state_q.dir),
        .pin_sync (pin_sync),
        .word     (rd_word)
    );

    always_comb begin
        state_d = state_q;
        if (bus_en && bus_we) begin
            case (acc_kind)
                ACC_DATA: state_d.out = (state_q.out & ~acc_mask) | (wr_byte & acc_mask);
                ACC_DIR:  state_d.dir = wr_byte;
                default:  ;
            endcase
        end
        if (bus_en && !bus_we) begin
            state_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bus_rdata = state_q.rdata;
    assign pad_out   = state_q.out;
    assign pad_oe    = state_q.dir;
endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
    parameter int             NPINS      = 8,
    parameter int             AW         = 12,
    parameter int             DW         = 32,
    parameter logic [AW-1:0]  DIR_OFFSET = 'h400
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [DW-1:0]    bus_rdata,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe
);
    logic             in_data;
    logic             in_dir;
    logic [NPINS-1:0] msk;
    logic             chk_unused;

    assign in_data    = (bus_addr[AW-1:NPINS+2] == '0);
    assign in_dir     = (bus_addr[AW-1:2] == DIR_OFFSET[AW-1:2]);
    assign msk        = bus_addr[NPINS+1:2];
    assign chk_unused = ^{bus_wdata[DW-1:NPINS], bus_addr[1:0]};

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pad_out == '0 && pad_oe == '0 && bus_rdata == '0));

    p_masked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && in_data) |=>
        pad_out == (($past(pad_out) & ~$past(msk)) | ($past(bus_wdata[NPINS-1:0]) & $past(msk))));

    p_idle_keeps_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we) |=> ($stable(pad_out) && $stable(pad_oe)));

    p_read_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && in_data) |=>
        (bus_rdata[DW-1:NPINS] == '0 && (bus_rdata[NPINS-1:0] & ~$past(msk)) == '0));

    p_output_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && in_data && pad_oe == '1) |=>
        bus_rdata[NPINS-1:0] == ($past(pad_out) & $past(msk)));

    p_dir_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && in_dir) |=> pad_oe == $past(bus_wdata[NPINS-1:0]));

    p_stray_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && !in_data && !in_dir) |=> ($stable(pad_out) && $stable(pad_oe)));

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_we) |=> $stable(bus_rdata));
endmodule

bind gpio_masked_port gpio_masked_port_chk #(
    .NPINS(NPINS), .AW(AW), .DW(DW), .DIR_OFFSET(DIR_OFFSET)
) u_chk (.*);

// File: tb/gpio_masked_port_test.sv
module gpio_masked_port_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_en = 0;
    logic        bus_we = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    logic [7:0] m_out = '0;
    logic [7:0] m_dir = '0;

    always #4 clk = ~clk;

    gpio_masked_port uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [31:0] model_read(input logic [11:0] a);
        logic [7:0] lvl;
        lvl = (m_dir & m_out) | (~m_dir & pad_in);
        if (a[11:10] == 2'b00)        return {24'h0, lvl & a[9:2]};
        else if (a[11:2] == 10'h100)  return {24'h0, m_dir};
        else                          return 32'h0;
    endfunction

    function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
        if (a[11:10] == 2'b00)        m_out = (m_out & ~a[9:2]) | (d[7:0] & a[9:2]);
        else if (a[11:2] == 10'h100)  m_dir = d[7:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
        model_write(a, d);
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] r);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_en = 0;
        r = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic [31:0] keep;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 pad_oe after reset", {24'h0, pad_oe}, 32'h0);
        check("R1 pad_out after reset", {24'h0, pad_out}, 32'h0);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        rst_n = 1;
        do_read(12'h400, r);
        check("R1 dir reads zero", r, 32'h0);

        // all outputs, full-port write via 0x3FC with junk in the upper bits
        do_write(12'h400, 32'hDEAD_BEFF);
        check("R7 pad_oe after dir write", {24'h0, pad_oe}, 32'hFF);
        do_read(12'h400, r);
        check("R7 dir readback", r, 32'h0000_00FF);
        do_write(12'h3FC, 32'hFFFF_FF3C);
        check("R8 full write", {24'h0, pad_out}, 32'h3C);
        check("R3 upper wdata ignored", {24'h0, pad_out}, 32'h3C);
        do_read(12'h3FC, r);
        check("R8 full read", r, 32'h0000_003C);

        // partial mask 0x0F at 0x03C, then zero mask
        do_write(12'h03C, 32'h0000_00FF);
        check("R2 masked write", {24'h0, pad_out}, 32'h3F);
        do_write(12'h000, 32'h0000_0000);
        check("R2 zero mask no change", {24'h0, pad_out}, 32'h3F);
        do_read(12'h204, r);
        check("R4 masked read 0x81", r, 32'h0000_0001);

        // stray addresses
        do_write(12'h800, 32'h0);
        do_write(12'h404, 32'h0);
        check("R9 stray write pad_out", {24'h0, pad_out}, 32'h3F);
        check("R9 stray write pad_oe", {24'h0, pad_oe}, 32'hFF);
        do_read(12'h3FC, r);
        do_read(12'h808, r);
        check("R9 stray read", r, 32'h0);
        do_read(12'h3FC, keep);
        repeat (4) @(negedge clk);
        check("R10 rdata held", bus_rdata, keep);

        // mixed direction
        do_write(12'h400, 32'h0000_00F0);
        pad_in = 8'h3C;
        repeat (3) @(negedge clk);
        do_read(12'h3FC, r);
        check("R5 mixed levels", r, model_read(12'h3FC));

        // synchronizer latency: all inputs, back-to-back reads
        do_write(12'h400, 32'h0);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'hA5;
        bus_en = 1; bus_we = 0; bus_addr = 12'h3FC;
        @(negedge clk);
        check("R6 first edge old", bus_rdata, 32'h0);
        @(negedge clk);
        check("R6 second edge old", bus_rdata, 32'h0);
        @(negedge clk);
        check("R6 third edge new", bus_rdata, 32'h0000_00A5);
        bus_en = 0;

        // constrained random
        for (int i = 0; i < 400; i++) begin
            int unsigned sel;
            logic [11:0] a;
            logic [31:0] d;
            sel = $urandom_range(0, 9);
            d = $urandom;
            case (sel)
                0, 1, 2: begin
                    a = {2'b00, 8'($urandom), 2'($urandom)};
                    do_write(a, d);
                    check("R2 random write", {24'h0, pad_out}, {24'h0, m_out});
                end
                3: begin
                    do_write(12'h400, d);
                    check("R7 random dir", {24'h0, pad_oe}, {24'h0, m_dir});
                end
                4, 5, 6: begin
                    a = {2'b00, 8'($urandom), 2'b00};
                    do_read(a, r);
                    check("R4 random read", r, model_read(a));
                end
                7: begin
                    a = 12'($urandom) | 12'h800;
                    if (sel[0]) do_write(a, d);
                    do_read(a, r);
                    check("R9 random stray", r, 32'h0);
                    check("R9 random stray pins", {16'h0, pad_oe, pad_out}, {16'h0, m_dir, m_out});
                end
                default: begin
                    pad_in = 8'($urandom);
                    repeat (3) @(negedge clk);
                    do_read(12'h3FC, r);
                    check("R5 random pad read", r, model_read(12'h3FC));
                end
            endcase
        end
        finish_run();
    end
endmodule